// File: doc/BRIEF.md
# ADC Scan Sequencer with Frame Tagging

This block drives a successive-approximation converter through a short, programmable scan list. A pacing counter produces conversion triggers at a fixed rate. On each trigger that it accepts, the block reads the next scan entry, which holds an attenuation code, a channel and a converter-unit select. It then issues a one-cycle request to an abstract converter port and waits for the result. Each result is packed together with its channel and unit into a 32-bit word and offered on a valid/ready output stream. Every Nth word carries a frame marker.

Software loads scan entries, the list length, the trigger interval, the frame size and an optional trigger limit through plain configuration pins. A start pulse begins a scan from the first entry. A stop pulse, or reaching the trigger limit, ends it once the conversion in flight has returned. The block keeps at most one conversion outstanding.

Trigger timing, sequencing and packing are handled here. The analog conversion is not.

The output stream follows the usual valid/ready rules. A word stays on `out_data` with `out_valid` high, unchanged, until a cycle in which `out_ready` is high. While the stream is stalled, no new conversion is started: a trigger that falls in a stalled cycle, or while a conversion is still pending, is discarded and recorded in a sticky overflow flag.

Top module: `adc_scan_seq`

## Requirements
- R1: Scan entries are written one at a time by index (0 to 6). A length write of 1 to 7 sets the number of active entries. A length write of 0 leaves the length unchanged. After reset the length is 1.
- R2: Each 6-bit entry maps to the request pins as follows: bits [1:0] are attenuation, bits [4:2] are channel, and bit 5 is unit. These three fields appear on the request pins in the cycle that `adc_req_valid` is high.
- R3: Accepted triggers step through the entries in index order. After the last active entry the sequence returns to entry 0. A start pulse restarts the sequence at entry 0.
- R4: While running, a trigger occurs every 2·max(interval, 40) clock cycles. The first trigger comes 2·max(interval, 40) cycles after the start pulse.
- R5: With the limit enabled, exactly `cfg_limit` conversions are requested after a start, and the block then goes idle. A start clears the trigger count.
- R6: An output word holds the 13-bit result in bits [12:0], the channel in bits [15:13] and the unit in bit 16. Bits [31:17] are zero.
- R7: `out_eof` is high on exactly the words whose 1-based index since start is a multiple of `cfg_eof_num`. A value of 0 never marks a word. The count restarts on start and on stop.
- R8: `out_bad` is high with a word when its channel is greater than or equal to the supported channel count (5 by default).
- R9: A trigger that arrives while a conversion is pending, or while the output is stalled, is dropped and sets `overflow`. The flag stays set until the next start.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_eof` hold their values.
- R11: After a stop pulse, no further request is issued. `busy` stays high until the pending result has returned, and then falls.
- R12: After reset, `out_valid`, `adc_req_valid`, `busy` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ent_we | input | 1 | Write strobe for one scan entry |
| cfg_ent_idx | input | 3 | Index of the entry to write |
| cfg_ent_data | input | 6 | Entry value: {unit, channel[2:0], atten[1:0]} |
| cfg_len_we | input | 1 | Write strobe for the list length |
| cfg_len | input | 3 | New length (0 keeps the current length) |
| cfg_interval | input | 12 | Half trigger period in cycles, raised to at least 40 |
| cfg_limit_en | input | 1 | Enables the trigger limit |
| cfg_limit | input | 8 | Number of conversions per run when limited |
| cfg_eof_num | input | 12 | Words per frame (0 = no marker) |
| start | input | 1 | Pulse: begin scan at entry 0, clear counts and overflow |
| stop | input | 1 | Pulse: stop issuing triggers |
| adc_req_valid | output | 1 | One-cycle conversion request |
| adc_req_chan | output | 3 | Requested channel |
| adc_req_unit | output | 1 | Requested converter unit |
| adc_req_atten | output | 2 | Requested attenuation |
| adc_rsp_valid | input | 1 | Conversion result strobe |
| adc_rsp_data | input | 13 | Conversion result |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Packed result word |
| out_eof | output | 1 | Frame marker on this word |
| out_bad | output | 1 | Channel field out of supported range |
| busy | output | 1 | Running or a conversion pending |
| overflow | output | 1 | Sticky flag: a trigger was dropped |

## Verification
The embedded assertions check several properties on every cycle:
- two triggers are never back-to-back;
- no request is issued while a result is pending, once the limit count is reached, or while idle;
- the overflow flag is sticky;
- a stalled output word stays still;
- the upper word bits stay zero and the frame marker appears only on a valid word.

Other properties need the bench scenarios, which compute expected values themselves:
- the exact trigger spacing for each interval, including the raise to 40;
- the wrap order of the scan list for every length;
- the frame-marker positions for several frame sizes;
- packing against the scan table;
- the effect of a zero length write;
- drops caused by a slow converter or a held stream.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int ENT_W = 6;

  typedef struct packed {
    logic       unit;
    logic [2:0] chan;
    logic [1:0] atten;
  } scan_ent_t;
endpackage

// File: rtl/scan_pacer.sv
module scan_pacer #(
  parameter int IVL_W   = 12,
  parameter int IVL_MIN = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [IVL_W-1:0] ival,
  output logic             trig
);
  logic [IVL_W-1:0] eff, cnt;
  logic             phase, wrap;

  // half period is never shorter than the minimum
  assign eff  = (ival < IVL_W'(IVL_MIN)) ? IVL_W'(IVL_MIN) : ival;
  assign wrap = (cnt >= eff - 1'b1);
  assign trig = run && !clr && phase && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (clr || !run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  AST_TRIG_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig); // R4
endmodule

// File: rtl/scan_table.sv
module scan_table
  import scan_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  scan_ent_t     wr_ent,
  input  logic          len_we,
  input  logic [AW-1:0] len_in,
  input  logic          restart,
  input  logic          advance,
  output scan_ent_t     cur_ent
);
  scan_ent_t     tbl [DEPTH];
  logic [AW-1:0] len_q, ptr;

  assign cur_ent = tbl[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= AW'(1);
      ptr   <= '0;
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else begin
      if (wr_en && wr_addr < AW'(DEPTH)) tbl[wr_addr] <= wr_ent;
      if (len_we && len_in != '0)
        len_q <= (len_in > AW'(DEPTH)) ? AW'(DEPTH) : len_in;
      if (restart)      ptr <= '0;
      else if (advance) ptr <= (ptr + 1'b1 >= len_q) ? '0 : ptr + 1'b1;
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < AW'(DEPTH)); // R3
endmodule

// File: rtl/scan_framer.sv
module scan_framer #(
  parameter int RES_W  = 13,
  parameter int EOF_W  = 12,
  parameter int NUM_CH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [2:0]       chan,
  input  logic             unit,
  input  logic [RES_W-1:0] res,
  input  logic [EOF_W-1:0] eof_num,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             out_eof,
  output logic             out_bad
);
  localparam int PAD = 32 - RES_W - 4;

  logic [EOF_W-1:0] eof_cnt;
  logic             hit;

  assign hit = (eof_num != '0) && (eof_cnt + 1'b1 == eof_num);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_cnt   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eof   <= 1'b0;
      out_bad   <= 1'b0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= {{PAD{1'b0}}, unit, chan, res};
        out_eof   <= hit;
        out_bad   <= ({1'b0, chan} >= 4'(NUM_CH));
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        out_eof   <= 1'b0;
        out_bad   <= 1'b0;
      end
      if (clr)       eof_cnt <= '0;
      else if (load) eof_cnt <= hit ? '0 : eof_cnt + 1'b1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eof)); // R10
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[31:RES_W+4] == '0); // R6
  AST_EOF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid); // R7
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import scan_pkg::*;
#(
  parameter int DEPTH  = 7,
  parameter int IVL_W  = 12,
  parameter int IVL_MIN = 40,
  parameter int LIM_W  = 8,
  parameter int EOF_W  = 12,
  parameter int RES_W  = 13,
  parameter int NUM_CH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ent_we,
  input  logic [2:0]       cfg_ent_idx,
  input  logic [5:0]       cfg_ent_data,
  input  logic             cfg_len_we,
  input  logic [2:0]       cfg_len,
  input  logic [IVL_W-1:0] cfg_interval,
  input  logic             cfg_limit_en,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic [EOF_W-1:0] cfg_eof_num,
  input  logic             start,
  input  logic             stop,
  output logic             adc_req_valid,
  output logic [2:0]       adc_req_chan,
  output logic             adc_req_unit,
  output logic [1:0]       adc_req_atten,
  input  logic             adc_rsp_valid,
  input  logic [RES_W-1:0] adc_rsp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_eof,
  output logic             out_bad,
  output logic             busy,
  output logic             overflow
);
  localparam int AW = 3;

  scan_ent_t        cur;
  logic             run, outst, trig, accept, drop, stall, lim_hit, load;
  logic [LIM_W-1:0] trig_cnt;
  logic [2:0]       lat_chan;
  logic             lat_unit;

  assign stall   = out_valid && !out_ready;
  assign lim_hit = cfg_limit_en && (trig_cnt == cfg_limit);
  assign accept  = trig && !lim_hit && !outst && !stall;
  assign drop    = trig && !lim_hit && (outst || stall);
  assign load    = adc_rsp_valid && outst;

  assign adc_req_valid = accept;
  assign adc_req_chan  = cur.chan;
  assign adc_req_unit  = cur.unit;
  assign adc_req_atten = cur.atten;
  assign busy          = run || outst;

  scan_pacer #(.IVL_W(IVL_W), .IVL_MIN(IVL_MIN)) i_pacer (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(start),
    .ival(cfg_interval), .trig(trig));

  scan_table #(.DEPTH(DEPTH), .AW(AW)) i_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_ent_we), .wr_addr(cfg_ent_idx),
    .wr_ent(scan_ent_t'(cfg_ent_data)), .len_we(cfg_len_we), .len_in(cfg_len),
    .restart(start), .advance(accept), .cur_ent(cur));

  scan_framer #(.RES_W(RES_W), .EOF_W(EOF_W), .NUM_CH(NUM_CH)) i_framer (
    .clk(clk), .rst_n(rst_n), .clr(start || stop), .load(load),
    .chan(lat_chan), .unit(lat_unit), .res(adc_rsp_data),
    .eof_num(cfg_eof_num), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_eof(out_eof), .out_bad(out_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      outst    <= 1'b0;
      trig_cnt <= '0;
      overflow <= 1'b0;
      lat_chan <= '0;
      lat_unit <= 1'b0;
    end else begin
      if (start)                run <= 1'b1;
      else if (stop || lim_hit) run <= 1'b0;

      if (accept) begin
        outst    <= 1'b1;
        lat_chan <= cur.chan;
        lat_unit <= cur.unit;
      end else if (adc_rsp_valid) begin
        outst    <= 1'b0;
      end

      if (start)       trig_cnt <= '0;
      else if (accept) trig_cnt <= trig_cnt + 1'b1;

      if (start)     overflow <= 1'b0;
      else if (drop) overflow <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !start |=> overflow); // R9
  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    outst && !adc_rsp_valid |=> !adc_req_valid); // R9
  AST_LIMIT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_limit_en && trig_cnt == cfg_limit |-> !adc_req_valid); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !adc_req_valid); // R11
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_ent_we = 0, cfg_len_we = 0, cfg_limit_en = 0;
  logic [2:0]  cfg_ent_idx = 0, cfg_len = 0;
  logic [5:0]  cfg_ent_data = 0;
  logic [11:0] cfg_interval = 40, cfg_eof_num = 0;
  logic [7:0]  cfg_limit = 0;
  logic        start = 0, stop = 0;
  logic        adc_req_valid, adc_req_unit, adc_rsp_valid = 0;
  logic [2:0]  adc_req_chan;
  logic [1:0]  adc_req_atten;
  logic [12:0] adc_rsp_data = 0;
  logic        out_valid, out_ready = 1, out_eof, out_bad, busy, overflow;
  logic [31:0] out_data;

  adc_scan_seq i_adc_scan_seq (.*);

  initial forever #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int lat = 6, eff = 40, eofn = 0, elen = 1;
  bit chk_gap = 1, bp = 0, force_low = 0;
  logic [5:0] etab [7];
  int rq_k = 0, kr = 0, s_rsp = 0, s_mon = 0, cyc = 0, last_rq = 0;

  function automatic logic [12:0] rfun(int k, logic [2:0] c, logic u);
    return 13'(k * 97 + int'(c) * 5 + int'(u) * 11);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // converter model: one pending conversion, fixed latency
  initial begin
    int pend = 0;
    logic [2:0] m_ch = 0;
    logic m_un = 0;
    logic [5:0] e;
    forever begin
      @(negedge clk);
      cyc++;
      adc_rsp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          adc_rsp_valid = 1;
          adc_rsp_data  = rfun(s_rsp, m_ch, m_un);
          s_rsp++;
        end
      end
      if (adc_req_valid) begin
        e = etab[rq_k % elen];
        chk(adc_req_chan == e[4:2] && adc_req_unit == e[5] && adc_req_atten == e[1:0],
            "R2 R3 request fields", {adc_req_unit, adc_req_chan, adc_req_atten}, e);
        if (chk_gap && rq_k > 0)
          chk(cyc - last_rq == 2 * eff, "R4 trigger spacing", cyc - last_rq, 2 * eff);
        last_rq = cyc;
        rq_k++;
        m_ch = adc_req_chan;
        m_un = adc_req_unit;
        pend = lat;
      end
    end
  end

  // ready driver, changes away from both edges
  initial begin
    int rc = 0;
    forever begin
      @(posedge clk);
      #1;
      out_ready = force_low ? 1'b0 : (bp ? (rc % 3 != 0) : 1'b1);
      rc++;
    end
  end

  // output monitor
  initial begin
    logic hold_v = 0;
    logic [31:0] hold_d = 0;
    logic [5:0] e;
    logic [31:0] xw;
    forever begin
      @(negedge clk);
      if (hold_v) chk(out_valid && out_data == hold_d, "R10 stalled word held", out_data, hold_d);
      hold_v = out_valid && !out_ready;
      hold_d = out_data;
      if (out_valid && out_ready) begin
        e  = etab[kr % elen];
        xw = {15'b0, e[5], e[4:2], rfun(s_mon, e[4:2], e[5])};
        chk(out_data == xw, "R6 packed word", out_data, xw);
        chk(out_eof == (eofn != 0 && (kr + 1) % eofn == 0), "R7 frame marker", out_eof,
            (eofn != 0 && (kr + 1) % eofn == 0));
        chk(out_bad == (e[4:2] >= 5), "R8 channel range flag", out_bad, (e[4:2] >= 5));
        kr++;
        s_mon++;
      end
    end
  end

  task automatic load_table(int seed);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      cfg_ent_we   = 1;
      cfg_ent_idx  = 3'(i);
      cfg_ent_data = {1'((i + seed) % 2), 3'((i * 3 + seed) % 8), 2'(i % 4)};
      etab[i]      = cfg_ent_data;
    end
    @(negedge clk);
    cfg_ent_we = 0;
  endtask

  task automatic set_len(int l);
    @(negedge clk);
    cfg_len_we = 1;
    cfg_len    = 3'(l);
    if (l != 0) elen = l;
    @(negedge clk);
    cfg_len_we = 0;
  endtask

  task automatic start_run();
    @(negedge clk);
    rq_k  = 0;
    kr    = 0;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || out_valid);
  endtask

  task automatic set_cfg(int ival, int en, int lim, int ef);
    @(negedge clk);
    cfg_interval = 12'(ival);
    eff          = (ival < 40) ? 40 : ival;
    cfg_limit_en = 1'(en);
    cfg_limit    = 8'(lim);
    cfg_eof_num  = 12'(ef);
    eofn         = ef;
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=running expected=done");
    finish_run();
  end

  initial begin
    int n;
    for (int i = 0; i < 7; i++) etab[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !adc_req_valid && !busy && !overflow, "R12 reset state",
        {out_valid, adc_req_valid, busy, overflow}, 0);

    // sweep over list length and frame size
    for (int l = 1; l <= 7; l++) begin
      for (int ef = 1; ef <= 3; ef++) begin
        set_cfg((l == 3) ? 45 : ((l == 5) ? 7 : 40), 1, 9, ef);
        bp = (ef == 2);
        load_table(l + ef);
        set_len(l);
        start_run();
        wait_idle();
        chk(rq_k == 9, "R5 requests under limit", rq_k, 9);
        chk(kr == 9, "R5 words under limit", kr, 9);
      end
    end
    bp = 0;

    // zero length write keeps length 4
    set_len(4);
    set_len(0);
    set_cfg(40, 1, 8, 4);
    start_run();
    wait_idle();
    chk(rq_k == 8 && kr == 8, "R1 zero length keeps list", kr, 8);

    // slow converter: every other trigger dropped
    lat = 100;
    chk_gap = 0;
    set_cfg(40, 1, 3, 0);
    start_run();
    wait_idle();
    chk(overflow == 1, "R9 overflow after pending drop", overflow, 1);
    chk(rq_k == 3, "R9 accepted count with drops", rq_k, 3);

    // held stream: trigger dropped, word held
    lat = 4;
    force_low = 1;
    set_cfg(40, 1, 2, 0);
    start_run();
    chk(overflow == 0, "R9 start clears overflow", overflow, 0);
    repeat (300) @(negedge clk);
    chk(rq_k == 1 && out_valid, "R9 no request while stalled", rq_k, 1);
    chk(overflow == 1, "R9 overflow after stalled drop", overflow, 1);
    force_low = 0;
    wait_idle();
    chk(rq_k == 2, "R5 limit after stall", rq_k, 2);

    // stop while a conversion is in flight
    lat = 20;
    chk_gap = 1;
    set_cfg(40, 0, 0, 2);
    start_run();
    n = 0;
    while (n < 3) begin
      @(negedge clk);
      if (adc_req_valid) n++;
    end
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk(busy == 1, "R11 busy while result pending", busy, 1);
    n = 0;
    while (busy) begin
      @(negedge clk);
      n++;
    end
    chk(n <= 20, "R11 idle after result", n, 20);
    repeat (300) @(negedge clk);
    chk(rq_k == 3, "R11 no request after stop", rq_k, 3);
    chk(kr == 3, "R11 last word delivered", kr, 3);

    finish_run();
  end
endmodule